// File: doc/BRIEF.md
# Control-Register Bus Responder

This block is the target end of a narrow, strobe-driven control-register bus. A master places a 16-bit word on the data-in lines and raises one of four request strobes. The strobes are capture-address, capture-data, write and read. The responder performs the matching action on a small internal register file and raises a level acknowledge. The acknowledge stays high until the master has dropped every strobe. A full register write therefore takes three handshakes: latch the address, latch the pending data, then commit it with the write strobe. A read takes two: latch the address, then raise the read strobe.

The time from a strobe to its acknowledge is a parameter counted in clock cycles. Setting it very large lets the master's timeout path be exercised. The number of implemented registers is also a parameter. Addresses at or beyond that depth are still acknowledged, but they hold nothing. The bus is a four-phase request/acknowledge handshake rather than a stream, so it has no valid/ready pair. The master applies back-pressure by holding its strobe high: the responder will not leave the acknowledged state, or accept a new request, until all strobes are low.

Top module: `crb_responder`

## Requirements
- R1: While reset is asserted, and just after it is released, ack is low and dout is zero. Reset also clears every register, the latched address and the pending write data to zero.
- R2: A rising capture-address strobe stores the din word as the current address.
- R3: A rising capture-data strobe stores din as the pending write data and leaves every register unchanged.
- R4: A rising write strobe copies the pending data into the register at the current address.
- R5: A rising read strobe loads dout with the register at the current address. The value is valid by the time ack rises, and dout holds it until the next accepted read.
- R6: Let E be the first clock edge that samples a strobe high after it was low, with the block idle. Ack is high from exactly RESP_DELAY edges after E.
- R7: Ack stays high while any strobe is high. Ack falls on the first clock edge that samples all four strobes low.
- R8: A strobe that rises while an earlier request is still being timed, or while ack is high, performs no action and starts no new ack.
- R9: An address at or above DEPTH reads as zero and ignores writes, but is still acknowledged. A write there leaves register (address mod DEPTH) unchanged.
- R10: When several strobes rise on the same edge, only one action is taken. The order of precedence is capture-address, capture-data, write, then read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_din | input | DATA_W | Address or data word from the master |
| stb_addr | input | 1 | Capture-address strobe |
| stb_data | input | 1 | Capture-data strobe |
| stb_wr | input | 1 | Write-commit strobe |
| stb_rd | input | 1 | Read strobe |
| rsp_ack | output | 1 | Level acknowledge |
| rsp_dout | output | DATA_W | Read data |

## Verification
The hardest situations to reach from the ports are the ignored strobes: one raised during the response delay, one raised while ack is already high, and several raised on the same edge. A strict master never produces any of these. The bench drives the strobes directly rather than through its handshake task. It raises a write strobe one cycle into a capture-address delay. It raises a read strobe on top of a held, acknowledged strobe. It raises capture-address and write together. After each case it reads the affected registers back through the normal bus to show that the ignored request left no trace.

// File: rtl/crb_pkg.sv
package crb_pkg;
  localparam int unsigned NUM_STROBES = 4;

  // Strobe index order is also the precedence order (lowest index wins).
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_ADDR  = 3'd1,
    OP_DATA  = 3'd2,
    OP_WRITE = 3'd3,
    OP_READ  = 3'd4
  } crb_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_ACK  = 2'd2
  } crb_state_e;
endpackage

// File: rtl/crb_strobe_front.sv
module crb_strobe_front
  import crb_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_STROBES-1:0] strobes,
  input  logic                   accept,
  output crb_op_e                op,
  output logic                   any_high
);
  logic [NUM_STROBES-1:0] prev_q;
  logic [NUM_STROBES-1:0] rise;

  function automatic crb_op_e op_of(input int idx);
    case (idx)
      0:       return OP_ADDR;
      1:       return OP_DATA;
      2:       return OP_WRITE;
      default: return OP_READ;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= strobes;
  end

  assign rise     = strobes & ~prev_q;
  assign any_high = |strobes;

  // Walk from lowest precedence to highest so the highest one overwrites.
  always_comb begin
    op = OP_NONE;
    if (accept) begin
      for (int i = NUM_STROBES - 1; i >= 0; i--) begin
        if (rise[i]) op = op_of(i);
      end
    end
  end
endmodule

// File: rtl/crb_resp_timer.sv
module crb_resp_timer
  import crb_pkg::*;
#(
  parameter int unsigned RESP_DELAY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic any_high,
  output logic idle,
  output logic busy,
  output logic ack
);
  localparam int unsigned CNT_W = (RESP_DELAY < 2) ? 1 : $clog2(RESP_DELAY);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RESP_DELAY - 1);

  crb_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  initial begin
    if (RESP_DELAY < 1) $error("RESP_DELAY must be at least 1");
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (fire) begin
            state_q <= ST_BUSY;
            cnt_q   <= CNT_LOAD;
          end
        end
        ST_BUSY: begin
          if (cnt_q == '0) state_q <= ST_ACK;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_ACK: begin
          if (!any_high) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle = (state_q == ST_IDLE);
  assign busy = (state_q == ST_BUSY);
  assign ack  = (state_q == ST_ACK);
endmodule

// File: rtl/crb_regfile.sv
module crb_regfile
  import crb_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  crb_op_e           op,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] addr_q;
  logic [DATA_W-1:0] pend_q;
  logic [DATA_W-1:0] dout_q;
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  hit;
  logic [DATA_W-1:0] rd_val;

  // Full-width compare: out-of-range addresses hit no entry.
  for (genvar g = 0; g < DEPTH; g++) begin : g_hit
    assign hit[g] = (addr_q == DATA_W'(g));
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit[i]) rd_val = mem_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      pend_q <= '0;
      dout_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      case (op)
        OP_ADDR:  addr_q <= din;
        OP_DATA:  pend_q <= din;
        OP_READ:  dout_q <= rd_val;
        OP_WRITE: begin
          for (int i = 0; i < DEPTH; i++) begin
            if (hit[i]) mem_q[i] <= pend_q;
          end
        end
        default: ;
      endcase
    end
  end

  assign dout = dout_q;
endmodule

// File: rtl/crb_responder.sv
module crb_responder
  import crb_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned RESP_DELAY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              stb_addr,
  input  logic              stb_data,
  input  logic              stb_wr,
  input  logic              stb_rd,
  output logic              rsp_ack,
  output logic [DATA_W-1:0] rsp_dout
);
  logic [NUM_STROBES-1:0] strobes;
  crb_op_e                op;
  logic                   any_high;
  logic                   idle;
  logic                   busy;

  // Index order sets precedence: address, data, write, read.
  assign strobes = {stb_rd, stb_wr, stb_data, stb_addr};

  crb_strobe_front i_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .accept   (idle),
    .op       (op),
    .any_high (any_high)
  );

  crb_resp_timer #(.RESP_DELAY(RESP_DELAY)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (op != OP_NONE),
    .any_high (any_high),
    .idle     (idle),
    .busy     (busy),
    .ack      (rsp_ack)
  );

  crb_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (op),
    .din   (bus_din),
    .dout  (rsp_dout)
  );
endmodule

// File: rtl/crb_responder_chk.sv
module crb_responder_chk
  import crb_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              any_high,
  input crb_op_e           op,
  input logic              busy,
  input logic              ack,
  input logic [DATA_W-1:0] dout
);
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && any_high) |=> ack); // R7

  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !any_high) |=> !ack); // R7

  AST_ACK_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(busy)); // R6

  AST_NO_ACTION_WHILE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack || busy) |-> (op == OP_NONE)); // R8

  AST_DOUT_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> $past(op == OP_READ)); // R5
endmodule

bind crb_responder crb_responder_chk #(.DATA_W(DATA_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .any_high (any_high),
  .op       (op),
  .busy     (busy),
  .ack      (rsp_ack),
  .dout     (rsp_dout)
);

// File: tb/test_crb_responder.sv
`timescale 1ns/1ps
module test_crb_responder;
  localparam int unsigned DATA_W     = 16;
  localparam int unsigned DEPTH      = 8;
  localparam int unsigned RESP_DELAY = 4;
  localparam int          LIMIT      = 1000;

  localparam logic [1:0] K_ADDR = 2'd0, K_DATA = 2'd1, K_WR = 2'd2, K_RD = 2'd3;

  typedef struct packed {
    logic [1:0]  kind;
    logic [15:0] val;
    logic        chk;
    logic [15:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{K_ADDR, 16'h0003, 1'b0, 16'h0000, 8'd2},
    '{K_DATA, 16'hA5A5, 1'b0, 16'h0000, 8'd3},
    '{K_WR,   16'h0000, 1'b0, 16'h0000, 8'd4},
    '{K_RD,   16'h0000, 1'b1, 16'hA5A5, 8'd4},  // R4 R5
    '{K_ADDR, 16'h0000, 1'b0, 16'h0000, 8'd2},
    '{K_DATA, 16'h1111, 1'b0, 16'h0000, 8'd3},
    '{K_WR,   16'h0000, 1'b0, 16'h0000, 8'd4},
    '{K_ADDR, 16'h0007, 1'b0, 16'h0000, 8'd2},
    '{K_DATA, 16'h7777, 1'b0, 16'h0000, 8'd3},
    '{K_WR,   16'h0000, 1'b0, 16'h0000, 8'd4},
    '{K_ADDR, 16'h0000, 1'b0, 16'h0000, 8'd2},
    '{K_RD,   16'h0000, 1'b1, 16'h1111, 8'd2},  // R2
    '{K_ADDR, 16'h0007, 1'b0, 16'h0000, 8'd2},
    '{K_RD,   16'h0000, 1'b1, 16'h7777, 8'd2},
    '{K_ADDR, 16'h0009, 1'b0, 16'h0000, 8'd9},
    '{K_DATA, 16'hDEAD, 1'b0, 16'h0000, 8'd9},
    '{K_WR,   16'h0000, 1'b0, 16'h0000, 8'd9},
    '{K_RD,   16'h0000, 1'b1, 16'h0000, 8'd9},  // R9 out of range
    '{K_ADDR, 16'h0001, 1'b0, 16'h0000, 8'd9},
    '{K_RD,   16'h0000, 1'b1, 16'h0000, 8'd9},  // R9 alias untouched
    '{K_DATA, 16'h0BAD, 1'b0, 16'h0000, 8'd3},
    '{K_RD,   16'h0000, 1'b1, 16'h0000, 8'd3}   // R3 data alone changes nothing
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [DATA_W-1:0] bus_din = '0;
  logic              stb_addr = 1'b0, stb_data = 1'b0, stb_wr = 1'b0, stb_rd = 1'b0;
  logic              rsp_ack;
  logic [DATA_W-1:0] rsp_dout;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  crb_responder #(.DATA_W(DATA_W), .DEPTH(DEPTH), .RESP_DELAY(RESP_DELAY)) i_crb_responder (
    .clk(clk), .rst_n(rst_n), .bus_din(bus_din),
    .stb_addr(stb_addr), .stb_data(stb_data), .stb_wr(stb_wr), .stb_rd(stb_rd),
    .rsp_ack(rsp_ack), .rsp_dout(rsp_dout)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_stb(input logic [1:0] kind, input logic lvl);
    case (kind)
      K_ADDR: stb_addr = lvl;
      K_DATA: stb_data = lvl;
      K_WR:   stb_wr   = lvl;
      default: stb_rd  = lvl;
    endcase
  endtask

  task automatic wait_ack(output int lat);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!rsp_ack && lat < LIMIT);
  endtask

  // Full four-phase handshake; returns latency in cycles.
  task automatic bus_op(input logic [1:0] kind, input logic [15:0] v, output int lat);
    bus_din = v;
    set_stb(kind, 1'b1);
    wait_ack(lat);
    set_stb(kind, 1'b0);
    @(negedge clk);
    check("R7 ack falls after strobes low", {31'd0, rsp_ack}, 32'd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int lat;
    @(negedge clk);
    check("R1 ack low in reset", {31'd0, rsp_ack}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ack low after reset", {31'd0, rsp_ack}, 32'd0);
    check("R1 dout zero after reset", {16'd0, rsp_dout}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      bus_op(VECS[i].kind, VECS[i].val, lat);
      check("R6 response latency", lat, RESP_DELAY + 1);
      if (VECS[i].chk)
        check($sformatf("R%0d vector %0d read", VECS[i].req, i), {16'd0, rsp_dout}, {16'd0, VECS[i].exp});
    end

    // R7: ack holds while strobe stays up; R8: read raised during ack ignored
    bus_din = 16'h0000;
    stb_addr = 1'b1;
    wait_ack(lat);
    stb_rd = 1'b1;
    repeat (5) @(negedge clk);
    check("R7 ack held while strobe high", {31'd0, rsp_ack}, 32'd1);
    check("R8 read during ack leaves dout", {16'd0, rsp_dout}, 32'h0000);
    stb_addr = 1'b0;
    @(negedge clk);
    check("R7 ack held while one strobe remains", {31'd0, rsp_ack}, 32'd1);
    stb_rd = 1'b0;
    @(negedge clk);
    check("R7 ack low", {31'd0, rsp_ack}, 32'd0);
    repeat (RESP_DELAY + 3) @(negedge clk);
    check("R8 no late ack from ignored strobe", {31'd0, rsp_ack}, 32'd0);

    // R8: write raised during the response delay is ignored
    bus_op(K_DATA, 16'h5A5A, lat);
    bus_din = 16'h0004;
    stb_addr = 1'b1;
    @(negedge clk);
    stb_wr = 1'b1;
    wait_ack(lat);
    check("R6 latency with extra strobe", lat, RESP_DELAY);
    stb_addr = 1'b0; stb_wr = 1'b0;
    @(negedge clk);
    bus_op(K_RD, 16'h0, lat);
    check("R8 write during delay ignored", {16'd0, rsp_dout}, 32'h0000);

    // R10: address and write rise together: only address taken
    bus_din = 16'h0006;
    stb_addr = 1'b1; stb_wr = 1'b1;
    wait_ack(lat);
    stb_addr = 1'b0; stb_wr = 1'b0;
    @(negedge clk);
    bus_op(K_RD, 16'h0, lat);
    check("R10 simultaneous write not taken", {16'd0, rsp_dout}, 32'h0000);
    bus_op(K_WR, 16'h0, lat);
    bus_op(K_RD, 16'h0, lat);
    check("R10 address taken before write", {16'd0, rsp_dout}, 32'h5A5A);

    // R1: reset clears registers and pending data
    bus_op(K_ADDR, 16'h0005, lat);
    bus_op(K_DATA, 16'hC3C3, lat);
    bus_op(K_WR, 16'h0, lat);
    bus_op(K_RD, 16'h0, lat);
    check("R4 write before reset", {16'd0, rsp_dout}, 32'hC3C3);
    do_reset();
    check("R1 dout cleared", {16'd0, rsp_dout}, 32'h0000);
    bus_op(K_ADDR, 16'h0006, lat);
    bus_op(K_WR, 16'h0, lat);
    bus_op(K_RD, 16'h0, lat);
    check("R1 pending data cleared", {16'd0, rsp_dout}, 32'h0000);
    bus_op(K_ADDR, 16'h0005, lat);
    bus_op(K_RD, 16'h0, lat);
    check("R1 register cleared", {16'd0, rsp_dout}, 32'h0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule